// File: doc/BRIEF.md
# Strobed byte transmitter for slave boards

This block empties a buffer of 24-bit colour samples onto a shared 8-bit bus that feeds downstream slave boards. It does the work in the idle video lines that follow a captured line. A pulse on `cap_done_i` arms the block. After that it counts horizontal-sync falling edges. The first three lines after arming stay silent. On each of the next four lines the block reads 24 samples out of the buffer and sends each sample as three bytes. Every byte has its own strobe wire, and that strobe pulses while the byte sits steady on the bus.

The buffer sits outside the block and gives data combinationally for `rd_addr_o`. A sample uses ten clocks:
- one read cycle;
- then, for each of its three bytes, a setup cycle, a strobe cycle and a hold cycle.

A line's burst is therefore 240 clocks long. A slave-facing latch enable stays high from the start of the first transfer line to the end of the last one. A pulse on `cap_start_i` means a new capture has begun. It drops whatever has not yet been sent.

Top module: `slv_bus_tx`

## Requirements
- R1: After `cap_done_i`, the first 3 hsync falling edges (high to low on `hsync_i`) start lines that produce no strobe, keep `busy_o` low and keep `latch_en_o` low.
- R2: Each of the 4th to 7th falling edges after arming starts a burst. `busy_o` rises in the first cycle after the clock edge that samples `hsync_i` low, stays high for exactly 240 cycles, and the burst carries exactly 72 strobes.
- R3: Samples go out from buffer addresses 0 to 95 in rising order, 24 per line. `rd_addr_o` shows 24×k in the first cycle of transfer line k (k = 0..3). Every new arming restarts at address 0.
- R4: A sample goes out as three bytes: bits 23:16 with `strobe_o[2]`, then bits 15:8 with `strobe_o[1]`, then bits 7:0 with `strobe_o[0]`.
- R5: At most one strobe bit is high at a time, and it is high for exactly one cycle. `bus_o` holds the same byte in the cycle before the strobe, during it and in the cycle after it.
- R6: `latch_en_o` rises with the first burst and stays high through the gaps between the four bursts. It falls in the cycle after the last burst ends. It is high whenever `busy_o` is high.
- R7: A `cap_start_i` pulse drives `busy_o`, `latch_en_o`, `strobe_o` and `bus_o` to zero in the next cycle. The hsync edges that follow send nothing until the block is armed again.
- R8: `bus_o` is zero and no strobe is high whenever `busy_o` is low.
- R9: Hsync falling edges that arrive before any arming, or after the 7th line of an armed sequence, have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_i | input | 1 | Horizontal sync, active high; a falling edge starts a line |
| cap_start_i | input | 1 | One-cycle pulse: a new capture begins, abort the transfer |
| cap_done_i | input | 1 | One-cycle pulse: the buffer is full, arm the 7-line sequence |
| rd_addr_o | output | 7 | Buffer read address |
| rd_data_i | input | 24 | Buffer data for `rd_addr_o`, combinational |
| bus_o | output | 8 | Shared slave data bus |
| strobe_o | output | 3 | Per-byte strobes, one-hot pulses |
| latch_en_o | output | 1 | Slave bus latch enable for the transfer phase |
| busy_o | output | 1 | Burst in progress |

## Verification
The bench fills the buffer model with an arithmetic pattern. It then predicts every byte and strobe index from the sample and byte counters alone, so a swapped byte order or strobe mapping shows up as a data mismatch on the first sample. Exact counts of busy cycles and strobes per line catch three kinds of fault:
- an off-by-one in the three-line skip, where data goes out on line 3 or line 8;
- a burst that is one sample short or long;
- a missing read cycle, which shortens the burst below 240 cycles.

A second frame, and a frame after an abort partway through a line, check that the pointer goes back to address 0. Without that, the second frame would start at address 96 and send the wrong data. Extra hsync edges with no arming, and the edges after an abort, must leave the strobes silent; a sequencer that never disarms would send an extra burst.

// File: rtl/slv_tx_pkg.sv
package slv_tx_pkg;
  typedef enum logic [1:0] {
    PH_LOAD   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;
endpackage

// File: rtl/slv_tx_edge.sv
module slv_tx_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic fall_o
);
  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  end

  assign fall_o = sig_q & ~sig_i;
endmodule

// File: rtl/slv_tx_line_seq.sv
module slv_tx_line_seq #(
  parameter int IDLE_LINES = 7,
  parameter int XFER_LINES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hs_fall_i,
  input  logic cap_start_i,
  input  logic cap_done_i,
  input  logic train_done_i,
  output logic start_o,
  output logic first_o,
  output logic kill_o,
  output logic latch_en_o
);
  localparam int CNT_W      = $clog2(IDLE_LINES + 1);
  localparam int FIRST_XFER = IDLE_LINES - XFER_LINES;

  logic             armed_q, xfer_q, last_q;
  logic [CNT_W-1:0] line_q;
  logic             line_go, in_window, final_line;

  assign kill_o     = cap_start_i | cap_done_i;
  assign line_go    = hs_fall_i & armed_q & ~kill_o;
  assign in_window  = (line_q >= CNT_W'(FIRST_XFER)) && (line_q < CNT_W'(IDLE_LINES));
  assign start_o    = line_go & in_window;
  assign first_o    = line_go & (line_q == CNT_W'(FIRST_XFER));
  assign final_line = line_go & (line_q == CNT_W'(IDLE_LINES - 1));
  assign latch_en_o = xfer_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      xfer_q  <= 1'b0;
      last_q  <= 1'b0;
      line_q  <= '0;
    end else if (cap_start_i) begin
      armed_q <= 1'b0;
      xfer_q  <= 1'b0;
      last_q  <= 1'b0;
      line_q  <= '0;
    end else if (cap_done_i) begin
      armed_q <= 1'b1;
      xfer_q  <= 1'b0;
      last_q  <= 1'b0;
      line_q  <= '0;
    end else begin
      if (line_go) begin
        line_q <= line_q + CNT_W'(1);
        if (line_q == CNT_W'(IDLE_LINES - 1)) armed_q <= 1'b0;
      end
      if (first_o)    xfer_q <= 1'b1;
      if (final_line) last_q <= 1'b1;
      // the last line's burst closes the transfer phase
      if (train_done_i && last_q) begin
        xfer_q <= 1'b0;
        last_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/slv_tx_byte_seq.sv
module slv_tx_byte_seq
  import slv_tx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int LANES   = 3,
  parameter int SAMPLES = 24,
  parameter int DEPTH   = 96,
  localparam int WORD_W = DATA_W * LANES,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              first_i,
  input  logic              kill_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [WORD_W-1:0] rd_data_i,
  output logic [DATA_W-1:0] bus_o,
  output logic [LANES-1:0]  strobe_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int SMP_W  = (SAMPLES > 1) ? $clog2(SAMPLES) : 1;

  phase_e            phase_q;
  logic              run_q;
  logic [LANE_W-1:0] lane_q;
  logic [SMP_W-1:0]  smp_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [WORD_W-1:0] word_q;
  logic              last_lane, last_smp;

  assign last_lane = lane_q == LANE_W'(LANES - 1);
  assign last_smp  = smp_q == SMP_W'(SAMPLES - 1);
  assign done_o    = run_q && (phase_q == PH_HOLD) && last_lane && last_smp;
  assign busy_o    = run_q;
  assign rd_addr_o = ptr_q;
  assign bus_o     = (run_q && phase_q != PH_LOAD) ? word_q[WORD_W-1 -: DATA_W] : '0;

  // byte n of a sample pairs with strobe LANES-1-n
  for (genvar g = 0; g < LANES; g++) begin : g_stb
    assign strobe_o[g] = run_q && (phase_q == PH_STROBE) && (lane_q == LANE_W'(LANES - 1 - g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      phase_q <= PH_LOAD;
      lane_q  <= '0;
      smp_q   <= '0;
      ptr_q   <= '0;
      word_q  <= '0;
    end else if (kill_i) begin
      run_q   <= 1'b0;
      phase_q <= PH_LOAD;
      lane_q  <= '0;
      smp_q   <= '0;
      word_q  <= '0;
    end else if (start_i) begin
      run_q   <= 1'b1;
      phase_q <= PH_LOAD;
      lane_q  <= '0;
      smp_q   <= '0;
      if (first_i) ptr_q <= '0;
    end else if (run_q) begin
      unique case (phase_q)
        PH_LOAD: begin
          word_q  <= rd_data_i;
          ptr_q   <= ptr_q + ADDR_W'(1);
          lane_q  <= '0;
          phase_q <= PH_SETUP;
        end
        PH_SETUP:  phase_q <= PH_STROBE;
        PH_STROBE: phase_q <= PH_HOLD;
        PH_HOLD: begin
          word_q <= word_q << DATA_W;
          if (last_lane) begin
            lane_q  <= '0;
            phase_q <= PH_LOAD;
            if (last_smp) begin
              run_q <= 1'b0;
              smp_q <= '0;
            end else begin
              smp_q <= smp_q + SMP_W'(1);
            end
          end else begin
            lane_q  <= lane_q + LANE_W'(1);
            phase_q <= PH_SETUP;
          end
        end
        default: phase_q <= PH_LOAD;
      endcase
    end
  end
endmodule

// File: rtl/slv_bus_tx.sv
module slv_bus_tx #(
  parameter int DATA_W           = 8,
  parameter int LANES            = 3,
  parameter int SAMPLES_PER_LINE = 24,
  parameter int IDLE_LINES       = 7,
  parameter int XFER_LINES       = 4,
  localparam int WORD_W = DATA_W * LANES,
  localparam int DEPTH  = SAMPLES_PER_LINE * XFER_LINES,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hsync_i,
  input  logic              cap_start_i,
  input  logic              cap_done_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [WORD_W-1:0] rd_data_i,
  output logic [DATA_W-1:0] bus_o,
  output logic [LANES-1:0]  strobe_o,
  output logic              latch_en_o,
  output logic              busy_o
);
  logic hs_fall, start, first, kill, train_done;

  slv_tx_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (hsync_i),
    .fall_o (hs_fall)
  );

  slv_tx_line_seq #(
    .IDLE_LINES (IDLE_LINES),
    .XFER_LINES (XFER_LINES)
  ) u_line (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .hs_fall_i    (hs_fall),
    .cap_start_i  (cap_start_i),
    .cap_done_i   (cap_done_i),
    .train_done_i (train_done),
    .start_o      (start),
    .first_o      (first),
    .kill_o       (kill),
    .latch_en_o   (latch_en_o)
  );

  slv_tx_byte_seq #(
    .DATA_W  (DATA_W),
    .LANES   (LANES),
    .SAMPLES (SAMPLES_PER_LINE),
    .DEPTH   (DEPTH)
  ) u_byte (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .first_i   (first),
    .kill_i    (kill),
    .rd_addr_o (rd_addr_o),
    .rd_data_i (rd_data_i),
    .bus_o     (bus_o),
    .strobe_o  (strobe_o),
    .busy_o    (busy_o),
    .done_o    (train_done)
  );
endmodule

// File: rtl/slv_bus_tx_chk.sv
module slv_bus_tx_chk #(
  parameter int DATA_W = 8,
  parameter int LANES  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cap_start_i,
  input logic [DATA_W-1:0] bus_o,
  input logic [LANES-1:0]  strobe_o,
  input logic              latch_en_o,
  input logic              busy_o
);
  // R5
  strobe_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(strobe_o));
  // R5
  strobe_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |strobe_o |=> strobe_o == '0);
  // R5
  strobe_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |strobe_o |-> $stable(bus_o));
  // R5
  strobe_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |strobe_o |=> $stable(bus_o));
  // R6
  busy_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> latch_en_o);
  // R8
  idle_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (bus_o == '0) && (strobe_o == '0));
  // R7
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_start_i |=> !busy_o && !latch_en_o);
endmodule

bind slv_bus_tx slv_bus_tx_chk #(
  .DATA_W (DATA_W),
  .LANES  (LANES)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cap_start_i (cap_start_i),
  .bus_o       (bus_o),
  .strobe_o    (strobe_o),
  .latch_en_o  (latch_en_o),
  .busy_o      (busy_o)
);

// File: tb/slv_bus_tx_tb.sv
module slv_bus_tx_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        hsync = 1'b0;
  logic        cap_start = 1'b0;
  logic        cap_done = 1'b0;
  logic [6:0]  rd_addr;
  logic [23:0] rd_data;
  logic [7:0]  bus;
  logic [2:0]  strobe;
  logic        latch_en, busy;

  int checks = 0;
  int errors = 0;
  int nstb = 0;
  int frame_id = 0;
  bit mon_on = 1'b0;

  always #2 clk = ~clk;

  function automatic logic [23:0] word_of(input int a);
    logic [7:0] b2, b1, b0;
    b2 = 8'(a * 7 + 3);
    b1 = 8'(a * 29 + 64);
    b0 = 8'(a ^ 165);
    return {b2, b1, b0};
  endfunction

  assign rd_data = word_of(int'(rd_addr));

  slv_bus_tx u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .hsync_i     (hsync),
    .cap_start_i (cap_start),
    .cap_done_i  (cap_done),
    .rd_addr_o   (rd_addr),
    .rd_data_i   (rd_data),
    .bus_o       (bus),
    .strobe_o    (strobe),
    .latch_en_o  (latch_en),
    .busy_o      (busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // byte/strobe monitor
  int       exp_k = 0, exp_j = 0, seen_frame = 0;
  bit       hold_pend = 1'b0;
  logic [7:0] prev_bus = '0;
  logic [2:0] prev_stb = '0;
  always @(negedge clk) begin
    logic [2:0] es;
    logic [7:0] eb;
    if (mon_on) begin
      if (seen_frame != frame_id) begin
        seen_frame = frame_id;
        exp_k = 0;
        exp_j = 0;
      end
      if (hold_pend) begin
        chk(bus == prev_bus && strobe == 3'b0, "R5", int'(bus), int'(prev_bus));
        hold_pend = 1'b0;
      end
      if (!busy) chk(bus == 8'h0 && strobe == 3'b0, "R8", int'({strobe, bus}), 0);
      if (strobe != 3'b0) begin
        es = 3'(1 << (2 - exp_j));
        eb = 8'(word_of(exp_k) >> (8 * (2 - exp_j)));
        chk(strobe == es, "R4", int'(strobe), int'(es));
        chk(bus == eb, "R3", int'(bus), int'(eb));
        chk(prev_bus == bus && prev_stb == 3'b0, "R5", int'(prev_bus), int'(bus));
        nstb++;
        hold_pend = 1'b1;
        if (exp_j == 2) begin
          exp_j = 0;
          exp_k++;
        end else begin
          exp_j++;
        end
      end
      prev_bus = bus;
      prev_stb = strobe;
    end
  end

  task automatic hs_line(input bit xfer, input int base, input bit latch_after, input string tag);
    int s0, nb;
    hsync = 1'b1;
    repeat (20) @(negedge clk);
    hsync = 1'b0;
    s0 = nstb;
    @(negedge clk);
    chk(busy == xfer, tag, int'(busy), int'(xfer));
    chk(latch_en == xfer, xfer ? "R6" : tag, int'(latch_en), int'(xfer));
    if (xfer) chk(rd_addr == 7'(base), "R3", int'(rd_addr), base);
    nb = busy ? 1 : 0;
    repeat (279) begin
      @(negedge clk);
      if (busy) nb++;
    end
    chk(nb == (xfer ? 240 : 0), tag, nb, xfer ? 240 : 0);
    chk(nstb - s0 == (xfer ? 72 : 0), tag, nstb - s0, xfer ? 72 : 0);
    chk(latch_en == latch_after, "R6", int'(latch_en), int'(latch_after));
  endtask

  task automatic arm();
    frame_id++;
    cap_done = 1'b1;
    @(negedge clk);
    cap_done = 1'b0;
  endtask

  task automatic do_frame();
    int s0;
    arm();
    s0 = nstb;
    for (int i = 0; i < 3; i++) hs_line(1'b0, 0, 1'b0, "R1");
    for (int i = 3; i < 7; i++) hs_line(1'b1, (i - 3) * 24, i < 6, "R2");
    chk(nstb - s0 == 288, "R3", nstb - s0, 288);
  endtask

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && latch_en == 1'b0, "R8", int'({busy, latch_en}), 0);
    chk(strobe == 3'b0 && bus == 8'h0, "R8", int'({strobe, bus}), 0);
    chk(rd_addr == 7'd0, "R3", int'(rd_addr), 0);
    mon_on = 1'b1;

    hs_line(1'b0, 0, 1'b0, "R9");
    hs_line(1'b0, 0, 1'b0, "R9");
    do_frame();
    hs_line(1'b0, 0, 1'b0, "R9");
    do_frame();

    // abort inside the first transfer line
    arm();
    for (int i = 0; i < 3; i++) hs_line(1'b0, 0, 1'b0, "R1");
    hsync = 1'b1;
    repeat (20) @(negedge clk);
    hsync = 1'b0;
    repeat (101) @(negedge clk);
    chk(busy == 1'b1, "R2", int'(busy), 1);
    cap_start = 1'b1;
    @(negedge clk);
    cap_start = 1'b0;
    chk(busy == 1'b0 && latch_en == 1'b0, "R7", int'({busy, latch_en}), 0);
    chk(strobe == 3'b0 && bus == 8'h0, "R7", int'({strobe, bus}), 0);
    s0 = nstb;
    repeat (178) @(negedge clk);
    for (int i = 0; i < 3; i++) hs_line(1'b0, 0, 1'b0, "R7");
    chk(nstb == s0, "R7", nstb - s0, 0);

    do_frame();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule